// File: doc/BRIEF.md
# Overlay Engine Control Sequencer

This block is the control and status front end of a four-layer display overlay engine. Software reaches it through a 32-bit register port with one address, a write strobe, write data and a combinational read bus. The block holds the soft reset, the engine enable, the interrupt enable, the interrupt status, the datapath enable, one read-channel enable per layer and the layer-source enable bits. The pixel datapath itself sits outside the block. Here it is seen only as a busy/idle input and a frame-done pulse.

Two commands drive a hardware sequencer. A start command turns on, one per cycle, the frame interrupt enable, then the engine, then the datapath. A stop command reverses the order. It clears the interrupt enable, the engine enable and the pending status in three cycles. It then waits for the datapath to go idle. Only then does it tear down the datapath enable, every read channel and every layer source. If the engine does not go idle within a bounded number of cycles, the sequencer gives up and flags a stop failure.

Layer-source and read-channel enables can be changed only while the datapath reports idle. A write made while the datapath is busy is dropped and recorded in a sticky error bit.

Top module: `layerMixCtrl`

## Requirements
- R1: While the hold bit (bit 0 of word 1) is 1, the engine enable, datapath enable, interrupt enable, interrupt status, error bits, layer sources and read channels are held at 0, and other writes to them are ignored. After the bit is written back to 0, all layers stay inactive. The region register and the hold bit itself keep their values.
- R2: Writing bit 0 = 1 to the command word (word 0) sets the interrupt enable one cycle after the write edge, the engine enable the cycle after that, and the datapath enable the cycle after that. The state word (word 2) reads {datapath, engine, irq enable} in bits 2:0.
- R3: Writing bit 1 = 1 to the command word clears the interrupt enable, then the engine enable, then the interrupt status, in three consecutive cycles. The sequencer then waits for the datapath to be idle. In the cycle after idle is seen, it clears the datapath enable, all read channels and all layer sources at once. Bit 1 has priority over bit 0.
- R4: The source word (word 5) holds one enable per layer in bits 3:0. Each read channel i is bit 0 of word 6+i. The output layerOn[i] is the AND of source bit i and channel i.
- R5: A write to the source word or to a channel word while engineBusy is 1 leaves all layer state unchanged and sets bit 0 of the error word (word 10). Writing 1 to an error bit clears it.
- R6: The region word (word 4) reads back as written. Its bits 31:16 drive roiHeight and its bits 15:0 drive roiWidth.
- R7: If engineBusy stays 1 for TIMEOUT cycles of the idle wait, the sequencer abandons the stop. It sets bit 1 of the error word, which drives stopFail, and skips the teardown.
- R8: The interrupt status (bit 0 of word 3) sets on a frameDone pulse only while the interrupt enable is 1. Writing 0 to it clears it, and writing 1 has no effect. The irq output follows its level.
- R9: Reads of unmapped words (12 to 15) return 0. Writes to the read-only state word (2) and status word (11: bit 0 idle, bit 1 sequencer running) have no effect.
- R10: A command written while a start or stop sequence is running is ignored. The command word reads 1 in bit 0 while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| engineBusy | input | 1 | Datapath busy, 0 means idle |
| frameDone | input | 1 | One-cycle pulse at end of frame |
| irq | output | 1 | Frame-complete interrupt level |
| engineOn | output | 1 | Engine enable |
| pathOn | output | 1 | Datapath enable |
| layerOn | output | LAYERS | Per-layer source AND read-channel enable |
| stopFail | output | 1 | Sticky stop-timeout error |
| roiWidth | output | 16 | Region width |
| roiHeight | output | 16 | Region height |

## Verification
The bench builds the block with LAYERS = 4 and ADDR_W = 4, which leaves four unmapped words for the read-as-zero check. It sets TIMEOUT = 16 instead of the large default, so that a stop abandoned after the full idle wait, and the skipped teardown that follows, happen within a few dozen cycles. With four layers, a source word and a channel word can be set to different masks, which shows that each layer is gated by both.

// File: rtl/layerMixPkg.sv
package layerMixPkg;

  // Fixed word addresses; the remaining ones are derived from LAYERS
  localparam int unsigned ADR_CMD   = 0;
  localparam int unsigned ADR_RST   = 1;
  localparam int unsigned ADR_STATE = 2;
  localparam int unsigned ADR_IRQ   = 3;
  localparam int unsigned ADR_ROI   = 4;
  localparam int unsigned ADR_SRC   = 5;
  localparam int unsigned ADR_CH0   = 6;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic setIrqEn;
    logic setEng;
    logic setPath;
    logic clrIrqEn;
    logic clrEng;
    logic clrStat;
    logic tearDown;
    logic failStop;
  } seqStrobeT;

endpackage

// File: rtl/mixSeqFsm.sv
module mixSeqFsm
  import layerMixPkg::*;
#(
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      softRst,
  input  logic      startReq,
  input  logic      stopReq,
  input  logic      engineBusy,
  output seqStrobeT strb,
  output logic      seqBusy
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ON_IRQ, S_ON_ENG, S_ON_PATH,
    S_OFF_IRQ, S_OFF_ENG, S_OFF_STAT, S_WAIT
  } seqStateT;

  seqStateT state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;

  always_comb begin
    stateNext   = state;
    waitCntNext = '0;
    strb        = '0;
    case (state)
      S_IDLE: begin
        if (stopReq)       stateNext = S_OFF_IRQ;
        else if (startReq) stateNext = S_ON_IRQ;
      end
      S_ON_IRQ:   begin strb.setIrqEn = 1'b1; stateNext = S_ON_ENG;   end
      S_ON_ENG:   begin strb.setEng   = 1'b1; stateNext = S_ON_PATH;  end
      S_ON_PATH:  begin strb.setPath  = 1'b1; stateNext = S_IDLE;     end
      S_OFF_IRQ:  begin strb.clrIrqEn = 1'b1; stateNext = S_OFF_ENG;  end
      S_OFF_ENG:  begin strb.clrEng   = 1'b1; stateNext = S_OFF_STAT; end
      S_OFF_STAT: begin strb.clrStat  = 1'b1; stateNext = S_WAIT;     end
      S_WAIT: begin
        if (!engineBusy) begin
          strb.tearDown = 1'b1;
          stateNext     = S_IDLE;
        end else if (waitCnt == CNT_LAST) begin
          strb.failStop = 1'b1;
          stateNext     = S_IDLE;
        end else begin
          waitCntNext = waitCnt + 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else if (softRst) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

  assign seqBusy = (state != S_IDLE);

endmodule

// File: rtl/mixCtrlRegs.sv
module mixCtrlRegs
  import layerMixPkg::*;
#(
  parameter int unsigned LAYERS = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              engineBusy,
  input  logic              frameDone,
  input  seqStrobeT         strb,
  input  logic              seqBusy,
  output logic              startReq,
  output logic              stopReq,
  output logic              softRst,
  output logic              irq,
  output logic              engineOn,
  output logic              pathOn,
  output logic [LAYERS-1:0] layerOn,
  output logic              stopFail,
  output logic              rejFlag,
  output logic [15:0]       roiWidth,
  output logic [15:0]       roiHeight
);

  localparam int unsigned ADR_ERR  = ADR_CH0 + LAYERS;
  localparam int unsigned ADR_STAT = ADR_ERR + 1;

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(ADR_CMD);
  localparam logic [ADDR_W-1:0] A_RST   = ADDR_W'(ADR_RST);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(ADR_STATE);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(ADR_IRQ);
  localparam logic [ADDR_W-1:0] A_ROI   = ADDR_W'(ADR_ROI);
  localparam logic [ADDR_W-1:0] A_SRC   = ADDR_W'(ADR_SRC);
  localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(ADR_ERR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_STAT);

  logic              rstHold;
  logic              irqEn, engEn, pathEn, irqStat;
  logic [LAYERS-1:0] srcEn, chEn, chWr;
  logic [1:0]        errBits;
  logic [31:0]       roiReg;
  logic              srcWr, layerWr, reject;

  assign softRst  = rstHold;
  assign startReq = wrEn && (addr == A_CMD) && wrData[0];
  assign stopReq  = wrEn && (addr == A_CMD) && wrData[1];
  assign srcWr    = wrEn && (addr == A_SRC);
  assign layerWr  = srcWr || (|chWr);
  assign reject   = !rstHold && layerWr && engineBusy;

  // Shared control and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstHold <= 1'b0;
      roiReg  <= '0;
      irqEn   <= 1'b0;
      engEn   <= 1'b0;
      pathEn  <= 1'b0;
      irqStat <= 1'b0;
      srcEn   <= '0;
      errBits <= '0;
    end else begin
      if (wrEn && (addr == A_RST)) rstHold <= wrData[0];
      if (wrEn && (addr == A_ROI)) roiReg  <= wrData;
      if (rstHold) begin
        irqEn   <= 1'b0;
        engEn   <= 1'b0;
        pathEn  <= 1'b0;
        irqStat <= 1'b0;
        srcEn   <= '0;
        errBits <= '0;
      end else begin
        if (strb.setIrqEn)      irqEn <= 1'b1;
        else if (strb.clrIrqEn) irqEn <= 1'b0;
        if (strb.setEng)        engEn <= 1'b1;
        else if (strb.clrEng)   engEn <= 1'b0;
        if (strb.setPath)       pathEn <= 1'b1;
        else if (strb.tearDown) pathEn <= 1'b0;

        if (strb.clrStat)                                irqStat <= 1'b0;
        else if (frameDone && irqEn)                     irqStat <= 1'b1;
        else if (wrEn && (addr == A_IRQ) && !wrData[0]) irqStat <= 1'b0;

        if (strb.tearDown)              srcEn <= '0;
        else if (srcWr && !engineBusy)  srcEn <= wrData[LAYERS-1:0];

        errBits <= ((wrEn && (addr == A_ERR)) ? (errBits & ~wrData[1:0]) : errBits)
                   | {strb.failStop, reject};
      end
    end
  end

  // One read-channel enable per layer
  for (genvar g = 0; g < LAYERS; g++) begin : gChan
    localparam logic [ADDR_W-1:0] A_MY = ADDR_W'(ADR_CH0 + g);
    assign chWr[g] = wrEn && (addr == A_MY);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          chEn[g] <= 1'b0;
      else if (rstHold || strb.tearDown)  chEn[g] <= 1'b0;
      else if (chWr[g] && !engineBusy)    chEn[g] <= wrData[0];
    end
  end

  // Read mux; unmapped words read zero
  always_comb begin
    rdData = '0;
    case (addr)
      A_CMD:   rdData[0]   = seqBusy;
      A_RST:   rdData[0]   = rstHold;
      A_STATE: rdData[2:0] = {pathEn, engEn, irqEn};
      A_IRQ:   rdData[0]   = irqStat;
      A_ROI:   rdData      = roiReg;
      A_SRC:   rdData[LAYERS-1:0] = srcEn;
      A_ERR:   rdData[1:0] = errBits;
      A_STAT:  rdData[1:0] = {seqBusy, !engineBusy};
      default: rdData      = '0;
    endcase
    for (int i = 0; i < LAYERS; i++) begin
      if (addr == ADDR_W'(ADR_CH0 + i)) rdData = {31'b0, chEn[i]};
    end
  end

  assign irq       = irqStat;
  assign engineOn  = engEn;
  assign pathOn    = pathEn;
  assign layerOn   = srcEn & chEn;
  assign stopFail  = errBits[1];
  assign rejFlag   = errBits[0];
  assign roiWidth  = roiReg[15:0];
  assign roiHeight = roiReg[31:16];

endmodule

// File: rtl/layerMixCtrl.sv
module layerMixCtrl
  import layerMixPkg::*;
#(
  parameter int unsigned LAYERS  = 4,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              engineBusy,
  input  logic              frameDone,
  output logic              irq,
  output logic              engineOn,
  output logic              pathOn,
  output logic [LAYERS-1:0] layerOn,
  output logic              stopFail,
  output logic [15:0]       roiWidth,
  output logic [15:0]       roiHeight
);

  seqStrobeT strb;
  logic      seqBusy, startReq, stopReq, softRst, rejFlag;

  mixSeqFsm #(.TIMEOUT(TIMEOUT)) uSeq (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .startReq(startReq), .stopReq(stopReq), .engineBusy(engineBusy),
    .strb(strb), .seqBusy(seqBusy)
  );

  mixCtrlRegs #(.LAYERS(LAYERS), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .engineBusy(engineBusy), .frameDone(frameDone),
    .strb(strb), .seqBusy(seqBusy), .startReq(startReq), .stopReq(stopReq),
    .softRst(softRst), .irq(irq), .engineOn(engineOn), .pathOn(pathOn),
    .layerOn(layerOn), .stopFail(stopFail), .rejFlag(rejFlag),
    .roiWidth(roiWidth), .roiHeight(roiHeight)
  );

endmodule

// File: rtl/layerMixCtrlChk.sv
module layerMixCtrlChk
  import layerMixPkg::*;
#(
  parameter int unsigned LAYERS = 4,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              engineBusy,
  input logic              frameDone,
  input logic              irq,
  input logic              engineOn,
  input logic              pathOn,
  input logic [LAYERS-1:0] layerOn,
  input logic              stopFail,
  input logic              softRst,
  input logic              rejFlag
);

  assert_hold_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!engineOn && !pathOn && !irq && !stopFail && layerOn == '0));

  assert_path_after_engine_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pathOn) |-> engineOn);

  assert_teardown_after_disable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pathOn) |-> !engineOn);

  assert_layer_rise_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((layerOn & ~$past(layerOn)) != '0) |-> $past(!engineBusy));

  assert_busy_write_flagged_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !softRst && engineBusy && addr == ADDR_W'(ADR_SRC)) |=> rejFlag);

  assert_fail_needs_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopFail) |-> $past(engineBusy));

  assert_irq_from_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(frameDone));

endmodule

bind layerMixCtrl layerMixCtrlChk #(.LAYERS(LAYERS), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .engineBusy(engineBusy),
  .frameDone(frameDone), .irq(irq), .engineOn(engineOn), .pathOn(pathOn),
  .layerOn(layerOn), .stopFail(stopFail), .softRst(softRst), .rejFlag(rejFlag)
);

// File: tb/tb_layerMixCtrl.sv
`timescale 1ns/1ps
module tb_layerMixCtrl;

  localparam int LAYERS = 4;
  localparam int ADDR_W = 4;
  localparam int TO     = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic engineBusy = 1'b0;
  logic frameDone = 1'b0;
  logic irq, engineOn, pathOn, stopFail;
  logic [LAYERS-1:0] layerOn;
  logic [15:0] roiWidth, roiHeight;

  always #2.5 clk = ~clk;

  layerMixCtrl #(.LAYERS(LAYERS), .ADDR_W(ADDR_W), .TIMEOUT(TO)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .engineBusy(engineBusy), .frameDone(frameDone),
    .irq(irq), .engineOn(engineOn), .pathOn(pathOn), .layerOn(layerOn),
    .stopFail(stopFail), .roiWidth(roiWidth), .roiHeight(roiHeight)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: pending actions kept in a queue
  // codes: 1 irqEn on, 2 engine on, 3 path on, 4 irqEn off, 5 engine off,
  //        6 status clear, 7 wait for idle
  int mIrqEn, mEng, mPath, mStat, mRej, mFail, mRst, waitCnt;
  bit [3:0] mSrc, mCh;
  bit [31:0] mRoi;
  int q[$];

  function automatic bit [31:0] mRead(input int a);
    case (a)
      0: return {31'b0, q.size() > 0};
      1: return 32'(mRst);
      2: return 32'({mPath[0], mEng[0], mIrqEn[0]});
      3: return 32'(mStat);
      4: return mRoi;
      5: return {28'b0, mSrc};
      6, 7, 8, 9: return {31'b0, mCh[a-6]};
      10: return 32'({mFail[0], mRej[0]});
      11: return 32'({q.size() > 0, !engineBusy});
      default: return 32'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mIrqEn = 0; mEng = 0; mPath = 0; mStat = 0; mRej = 0; mFail = 0;
      mRst = 0; waitCnt = 0; mSrc = 0; mCh = 0; mRoi = 0; q.delete();
    end else if (mRst != 0) begin
      mIrqEn = 0; mEng = 0; mPath = 0; mStat = 0; mRej = 0; mFail = 0;
      mSrc = 0; mCh = 0; waitCnt = 0; q.delete();
      if (wrEn && addr == 1) mRst = int'(wrData[0]);
      if (wrEn && addr == 4) mRoi = wrData;
    end else begin
      automatic int pIrqEn = mIrqEn;
      automatic bit pEmpty = (q.size() == 0);
      automatic bit tear = 0, fail = 0, clrS = 0, rej = 0;
      if (!pEmpty) begin
        case (q[0])
          1: begin mIrqEn = 1; void'(q.pop_front()); end
          2: begin mEng = 1; void'(q.pop_front()); end
          3: begin mPath = 1; void'(q.pop_front()); end
          4: begin mIrqEn = 0; void'(q.pop_front()); end
          5: begin mEng = 0; void'(q.pop_front()); end
          6: begin clrS = 1; void'(q.pop_front()); end
          default: begin
            if (!engineBusy) begin tear = 1; waitCnt = 0; void'(q.pop_front()); end
            else if (waitCnt == TO - 1) begin fail = 1; waitCnt = 0; void'(q.pop_front()); end
            else waitCnt++;
          end
        endcase
      end
      if (clrS) mStat = 0;
      else if (frameDone && pIrqEn != 0) mStat = 1;
      else if (wrEn && addr == 3 && !wrData[0]) mStat = 0;
      if (wrEn) begin
        case (int'(addr))
          0: if (pEmpty) begin
               if (wrData[1]) begin q.push_back(4); q.push_back(5); q.push_back(6); q.push_back(7); end
               else if (wrData[0]) begin q.push_back(1); q.push_back(2); q.push_back(3); end
             end
          1: mRst = int'(wrData[0]);
          4: mRoi = wrData;
          5: if (engineBusy) rej = 1; else mSrc = wrData[3:0];
          6, 7, 8, 9: if (engineBusy) rej = 1; else mCh[int'(addr)-6] = wrData[0];
          10: begin
                if (wrData[0]) mRej = 0;
                if (wrData[1]) mFail = 0;
              end
          default: ;
        endcase
      end
      if (rej) mRej = 1;
      if (fail) mFail = 1;
      if (tear) begin mPath = 0; mSrc = 0; mCh = 0; end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("model R2 R3 R4 R8",
          {irq, engineOn, pathOn, stopFail, layerOn, roiHeight, roiWidth, 8'b0},
          {mStat[0], mEng[0], mPath[0], mFail[0], mSrc & mCh, mRoi, 8'b0});
      chk("model read R9", {32'b0, rdData}, {32'b0, mRead(int'(addr))});
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      finishRun();
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdChk(input int a, input logic [31:0] exp, input string tag);
    addr = ADDR_W'(a);
    @(negedge clk);
    chk(tag, {32'b0, rdData}, {32'b0, exp});
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // reset state
    rdChk(2, 32'h0, "R1 reset state word");
    chk("R1 reset outputs", {59'b0, irq, engineOn, pathOn, stopFail, layerOn[0]}, 64'h0);

    // R6 region packing
    wr(4, 32'h01E0_0280);
    chk("R6 height", {48'b0, roiHeight}, 64'h1E0);
    chk("R6 width", {48'b0, roiWidth}, 64'h280);
    rdChk(4, 32'h01E0_0280, "R6 readback");

    // R4 layer gating while idle
    wr(5, 32'h5); wr(6, 1); wr(7, 1); wr(8, 1);
    chk("R4 src AND channel", {60'b0, layerOn}, 64'h5);
    wr(5, 32'h7);
    chk("R4 src widened", {60'b0, layerOn}, 64'h7);

    // R2 start order, one step per cycle
    wr(0, 1);
    addr = ADDR_W'(2);
    @(negedge clk); chk("R2 before first step", {32'b0, rdData}, 64'h0);
    @(negedge clk); chk("R2 irq enable first", {32'b0, rdData}, 64'h1);
    @(negedge clk); chk("R2 engine second", {32'b0, rdData}, 64'h3);
    @(negedge clk); chk("R2 datapath third", {32'b0, rdData}, 64'h7);
    @(posedge clk); #1;

    // R5 busy rejection
    engineBusy = 1'b1;
    wr(5, 32'hF); wr(9, 1);
    chk("R5 layers unchanged", {60'b0, layerOn}, 64'h7);
    rdChk(10, 32'h1, "R5 error bit");
    rdChk(9, 32'h0, "R5 channel unchanged");

    // R8 interrupt
    frameDone = 1'b1; idle(1); frameDone = 1'b0;
    chk("R8 irq set", {63'b0, irq}, 64'h1);
    wr(3, 1);
    chk("R8 write 1 no effect", {63'b0, irq}, 64'h1);
    wr(3, 0);
    chk("R8 write 0 clears", {63'b0, irq}, 64'h0);

    // R9 unmapped and read-only words
    rdChk(13, 32'h0, "R9 unmapped read");
    wr(11, 32'hFFFF_FFFF);
    rdChk(11, 32'h0, "R9 status write ignored");
    wr(2, 32'h0);
    rdChk(2, 32'h7, "R9 state write ignored");

    // R3 stop order with busy wait, R10 command ignored
    frameDone = 1'b1; idle(1); frameDone = 1'b0;
    wr(0, 2);
    addr = ADDR_W'(2);
    @(negedge clk); chk("R3 before first step", {32'b0, rdData}, 64'h7);
    @(negedge clk); chk("R3 irq enable off first", {32'b0, rdData}, 64'h6);
    @(negedge clk); chk("R3 engine off second", {32'b0, rdData}, 64'h4);
    @(negedge clk); chk("R3 status cleared third", {63'b0, irq}, 64'h0);
    chk("R3 layers held during wait", {60'b0, layerOn}, 64'h7);
    @(posedge clk); #1;
    rdChk(0, 32'h1, "R10 sequence running");
    wr(0, 1);
    idle(2);
    chk("R3 datapath held while busy", {63'b0, pathOn}, 64'h1);
    engineBusy = 1'b0;
    idle(1);
    chk("R3 teardown path", {63'b0, pathOn}, 64'h0);
    chk("R3 teardown layers", {60'b0, layerOn}, 64'h0);
    rdChk(5, 32'h0, "R3 sources cleared");
    idle(5);
    chk("R10 start ignored", {62'b0, engineOn, pathOn}, 64'h0);

    // R7 stop timeout
    wr(10, 3);
    rdChk(10, 32'h0, "R5 error cleared by write 1");
    wr(0, 1);
    idle(4);
    engineBusy = 1'b1;
    wr(0, 2);
    idle(TO + 8);
    chk("R7 stop failure", {63'b0, stopFail}, 64'h1);
    rdChk(10, 32'h2, "R7 error word");
    chk("R7 teardown skipped", {62'b0, engineOn, pathOn}, 64'h1);

    // R1 soft reset hold and release
    wr(1, 1);
    idle(1);
    chk("R1 hold clears", {60'b0, engineOn, pathOn, stopFail, irq}, 64'h0);
    engineBusy = 1'b0;
    wr(5, 32'hF); wr(6, 1);
    chk("R1 writes ignored while held", {60'b0, layerOn}, 64'h0);
    wr(1, 0);
    rdChk(5, 32'h0, "R1 layers inactive after release");
    rdChk(4, 32'h01E0_0280, "R1 region kept");

    idle(2);
    finishRun();
  end

endmodule